// File: doc/BRIEF.md
# Serial Converter Host Controller

This block is the host side of an 8-bit serial analog-to-digital converter that has a multiplexed input and no end-of-conversion signal. A consumer hands it a channel number on a valid/ready request port. The controller then runs one serial exchange: it lowers the active-low chip select, produces a divided serial clock, and sends the 5-bit channel number most significant bit first, followed by three zero filler bits. On the same eight clocks it shifts in the 8-bit result that the converter holds. That result belongs to the conversion started by the previous exchange. The controller returns it on a valid/ready response port. The converter cannot report when it has finished, so the controller times the conversion blindly. It counts a worst-case number of conversion-clock periods, using a one-cycle strobe that is shared with the converter's clock.

A parameter selects one of two sequences. In the continuous-clock sequence, chip select is raised on the eighth falling serial-clock edge and held high for the whole conversion wait. In the gated-clock sequence, chip select stays low after the first exchange and the serial clock is held low for the whole wait. Channel numbers of 24 and above put the converter into a factory test mode. They are refused and answered with an error response, and the serial pins do not move.

States: HOLDOFF (after reset, chip select high, wait out any conversion in flight), IDLE (accept a request), SETUP (chip select low, recognition delay), SHIFT (eight serial clocks), CONV (blind conversion wait), RESP (hold the response). Transitions: HOLDOFF→IDLE when the wait expires. IDLE→RESP on a refused channel. IDLE→SETUP on a good channel while chip select is high. IDLE→SHIFT on a good channel while chip select is already low (gated sequence). SETUP→SHIFT when the setup ticks expire. SHIFT→CONV on the eighth falling edge. CONV→RESP when the wait expires. RESP→IDLE on the response handshake.

Top module: `sadc_host_ctrl`

## Requirements
- R1: During and after reset, until CONV_TICKS conversion ticks have passed, chip select is high, the serial clock is low, req_ready is 0 and rsp_valid is 0.
- R2: req_ready is 1 only in the idle state. A request is taken on a cycle with req_valid and req_ready both high. req_ready stays 0 from acceptance until the response has been consumed.
- R3: A channel number of 24 or more is refused. The controller answers with rsp_err=1, rsp_data=0 and rsp_stale=0, and neither chip select nor the serial clock changes.
- R4: An exchange has exactly eight serial-clock pulses. The line adc_di carries the 5-bit channel number MSB first, then three 0 bits, and it never changes on a cycle in which the serial clock rises.
- R5: adc_do is sampled at each serial-clock rise, MSB first. The first bit is the one present from the fall of chip select. The 8-bit response holds the result of the conversion started by the previous accepted exchange.
- R6: In continuous mode (GATED_SCLK=0), chip select rises on the cycle of the eighth falling edge. It stays high for at least CONV_TICKS ticks before it falls again.
- R7: In gated mode (GATED_SCLK=1), chip select never rises after its first fall. The serial clock stays low for at least CONV_TICKS ticks after each eighth falling edge.
- R8: Each low pulse of chip select lasts at least SETUP_TICKS ticks. The first serial-clock rise comes at least SETUP_TICKS ticks after chip select falls.
- R9: The first accepted exchange after reset returns rsp_stale=1. All later ones return rsp_stale=0.
- R10: rsp_valid, rsp_data, rsp_err and rsp_stale hold steady until rsp_ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_tick | input | 1 | One-cycle strobe per converter clock period |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_chan | input | CHAN_W | Channel number for the next conversion |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_data | output | DATA_W | Result of the previous conversion |
| rsp_err | output | 1 | Channel refused |
| rsp_stale | output | 1 | Result predates any exchange since reset |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock |
| adc_di | output | 1 | Address bit to the converter |
| adc_do | input | 1 | Result bit from the converter |

## Verification
The bench builds two copies side by side, one with GATED_SCLK=0 and one with GATED_SCLK=1. Both use SCLK_HALF=2 and a conversion tick every third clock, so each exchange takes about a hundred and fifty cycles. With that small setup, every one of the 32 possible 5-bit channel codes can be swept in a permuted order through both sequences. The sweep covers the refused codes 24 to 31 mixed among good ones and the stale first result. A bench model of the converter computes each result from the address it received, so the previous-conversion pairing can be checked directly. Tick-stamped edges of chip select and the serial clock check the conversion wait and the setup timing.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
    typedef enum logic [2:0] {
        ST_HOLDOFF,
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_CONV,
        ST_RESP
    } ctl_state_e;
endpackage

// File: rtl/sadc_tick_timer.sv
module sadc_tick_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (tick && (cnt != '1))
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt >= limit);

    // R6: counter only moves on a tick or a clear
    a_r6_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) && !$past(clear) |-> $stable(cnt));
endmodule

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int CW = $clog2(HALF + 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == CW'(HALF - 1));
    assign rise = run && wrap && !sclk;
    assign fall = run && wrap && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            sclk <= !sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the serial clock never moves while stopped
    a_r4_clock_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> !sclk);
endmodule

// File: rtl/sadc_shift_unit.sv
module sadc_shift_unit #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] load_word,
    input  logic         rise,
    input  logic         fall,
    input  logic         ser_in,
    output logic         ser_out,
    output logic [N-1:0] rx_word,
    output logic         last
);
    localparam int BW = $clog2(N);

    logic [N-1:0]  tx;
    logic [BW-1:0] bit_cnt;

    assign ser_out = tx[N-1];
    assign last    = fall && (bit_cnt == BW'(N - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx      <= '0;
            rx_word <= '0;
            bit_cnt <= '0;
        end else if (load) begin
            tx      <= load_word;
            rx_word <= '0;
            bit_cnt <= '0;
        end else begin
            if (rise)
                rx_word <= {rx_word[N-2:0], ser_in};
            if (fall) begin
                tx      <= {tx[N-2:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sadc_host_ctrl.sv
module sadc_host_ctrl
    import sadc_pkg::*;
#(
    parameter int CHAN_W      = 5,
    parameter int DATA_W      = 8,
    parameter int CHAN_LIMIT  = 24,
    parameter int SCLK_HALF   = 4,
    parameter int SETUP_TICKS = 4,
    parameter int CONV_TICKS  = 32,
    parameter int GATED_SCLK  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_tick,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CHAN_W-1:0] req_chan,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic              rsp_stale,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic              adc_di,
    input  logic              adc_do
);
    localparam int PAD_W    = DATA_W - CHAN_W;
    localparam int TICK_MAX = (CONV_TICKS > SETUP_TICKS) ? CONV_TICKS : SETUP_TICKS;
    localparam int TW       = $clog2(TICK_MAX + 2);

    ctl_state_e state, state_nxt;

    logic          accept, chan_ok;
    logic          t_clear, t_done;
    logic [TW-1:0] t_limit;
    logic          sclk_run, sclk_rise, sclk_fall;
    logic          frame_last;
    logic [DATA_W-1:0] rx_word;
    logic          cs_n_q, first_pend;

    assign accept  = req_valid && req_ready;
    assign chan_ok = ({1'b0, req_chan} < (CHAN_W + 1)'(CHAN_LIMIT));

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_HOLDOFF;
        else
            state <= state_nxt;
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLDOFF: if (t_done) state_nxt = ST_IDLE;
            ST_IDLE: begin
                if (accept) begin
                    if (!chan_ok)
                        state_nxt = ST_RESP;
                    else if (cs_n_q)
                        state_nxt = ST_SETUP;
                    else
                        state_nxt = ST_SHIFT;
                end
            end
            ST_SETUP:   if (t_done) state_nxt = ST_SHIFT;
            ST_SHIFT:   if (frame_last) state_nxt = ST_CONV;
            ST_CONV:    if (t_done) state_nxt = ST_RESP;
            ST_RESP:    if (rsp_ready) state_nxt = ST_IDLE;
            default:    state_nxt = ST_HOLDOFF;
        endcase
    end

    // ---------------- state-decoded outputs ----------------
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_RESP);
        sclk_run  = (state == ST_SHIFT);
        t_clear   = (state_nxt != state);
        t_limit   = (state == ST_SETUP) ? TW'(SETUP_TICKS) : TW'(CONV_TICKS);
    end

    // ---------------- chip select, response, stale flag ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q     <= 1'b1;
            first_pend <= 1'b1;
            rsp_data   <= '0;
            rsp_err    <= 1'b0;
            rsp_stale  <= 1'b0;
        end else begin
            if (accept && !chan_ok) begin
                rsp_data  <= '0;
                rsp_err   <= 1'b1;
                rsp_stale <= 1'b0;
            end
            if (accept && chan_ok)
                cs_n_q <= 1'b0;
            if (frame_last) begin
                rsp_data   <= rx_word;
                rsp_err    <= 1'b0;
                rsp_stale  <= first_pend;
                first_pend <= 1'b0;
                if (GATED_SCLK == 0)
                    cs_n_q <= 1'b1;
            end
        end
    end

    assign adc_cs_n = cs_n_q;

    // ---------------- sub-blocks ----------------
    sadc_tick_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (t_clear),
        .tick  (conv_tick),
        .limit (t_limit),
        .done  (t_done)
    );

    sadc_sclk_gen #(.HALF(SCLK_HALF)) u_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sclk_run),
        .sclk  (adc_sclk),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    sadc_shift_unit #(.N(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && chan_ok),
        .load_word ({req_chan, {PAD_W{1'b0}}}),
        .rise      (sclk_rise),
        .fall      (sclk_fall),
        .ser_in    (adc_do),
        .ser_out   (adc_di),
        .rx_word   (rx_word),
        .last      (frame_last)
    );

    // ---------------- checker counters for chip-select pulse widths ----------------
    logic [TW-1:0] low_ticks, high_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_ticks  <= '0;
            high_ticks <= '0;
        end else begin
            if (cs_n_q)
                low_ticks <= '0;
            else if (conv_tick && (low_ticks != '1))
                low_ticks <= low_ticks + 1'b1;
            if (!cs_n_q)
                high_ticks <= '0;
            else if (conv_tick && (high_ticks != '1))
                high_ticks <= high_ticks + 1'b1;
        end
    end

    // ---------------- assertions ----------------
    a_r1_holdoff_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLDOFF) |-> (adc_cs_n && !adc_sclk && !req_ready && !rsp_valid));

    a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !adc_sclk));

    a_r3_refused_no_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !chan_ok) |=> (rsp_valid && rsp_err && $stable(adc_cs_n) && !adc_sclk));

    a_r4_di_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_sclk) |-> $stable(adc_di));

    a_r6_cs_high_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ((GATED_SCLK == 0) && $fell(adc_cs_n)) |-> ($past(high_ticks) >= TW'(CONV_TICKS)));

    a_r6_cs_high_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        ((GATED_SCLK == 0) && (state == ST_CONV)) |-> adc_cs_n);

    a_r7_cs_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((GATED_SCLK != 0) && !$past(adc_cs_n)) |-> !adc_cs_n);

    a_r7_sclk_low_conv: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV) |-> !adc_sclk);

    a_r8_cs_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |-> (low_ticks >= TW'(SETUP_TICKS)));

    a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) &&
                                       $stable(rsp_err) && $stable(rsp_stale)));
endmodule

// File: tb/sadc_host_ctrl_test.sv
`timescale 1ns/1ps

module sadc_host_ctrl_env #(
    parameter int GATED = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_tick,
    input  int   tick_total,
    output logic done
);
    localparam int CONV  = 32;
    localparam int SETUP = 4;

    logic       req_valid = 1'b0;
    logic       rsp_ready = 1'b0;
    logic [4:0] req_chan  = '0;
    logic       req_ready, rsp_valid, rsp_err, rsp_stale;
    logic [7:0] rsp_data;
    logic       cs_n, sclk, di, do_w;

    int n_run  = 0;
    int n_fail = 0;

    sadc_host_ctrl #(
        .SCLK_HALF(2), .SETUP_TICKS(SETUP), .CONV_TICKS(CONV), .GATED_SCLK(GATED)
    ) uut (
        .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick),
        .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_err(rsp_err), .rsp_stale(rsp_stale),
        .adc_cs_n(cs_n), .adc_sclk(sclk), .adc_di(di), .adc_do(do_w)
    );

    function automatic logic [7:0] conv_of(input logic [4:0] ch);
        return 8'((int'(ch) * 37 + 11) % 256);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (mode %0d) actual=%0h expected=%0h", tag, GATED, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    logic [7:0] m_out = 8'hA5;
    logic [7:0] m_res = 8'hA5;
    logic [7:0] m_in  = '0;
    logic [4:0] m_addr = '0;
    logic [2:0] m_pad  = '0;
    int m_bits = 0, rises = 0, cs_falls = 0;
    int t_fall8 = 0, t_csfall = 0;
    bit after8 = 0;

    assign do_w = m_out[7];

    always @(negedge cs_n) if (rst_n === 1'b1) begin
        cs_falls++;
        m_out    = m_res;
        t_csfall = tick_total;
        if (GATED == 0 && after8) begin
            chk(tick_total - t_fall8 >= CONV, "R6 cs high gap", tick_total - t_fall8, CONV);
            after8 = 0;
        end
    end

    always @(posedge cs_n) if (rst_n === 1'b1 && cs_falls > 0)
        chk(tick_total - t_csfall >= SETUP, "R8 cs low width", tick_total - t_csfall, SETUP);

    always @(posedge sclk) if (rst_n === 1'b1) begin
        rises++;
        m_in = {m_in[6:0], di};
        m_bits++;
        if (m_bits == 1) begin
            if (GATED != 0 && after8)
                chk(tick_total - t_fall8 >= CONV, "R7 sclk idle gap", tick_total - t_fall8, CONV);
            after8 = 0;
            chk(tick_total - t_csfall >= SETUP, "R8 setup to first rise",
                tick_total - t_csfall, SETUP);
        end
    end

    always @(negedge sclk) if (rst_n === 1'b1) begin
        if (m_bits == 8) begin
            m_addr  = m_in[7:3];
            m_pad   = m_in[2:0];
            m_res   = conv_of(m_addr);
            m_out   = m_res;
            m_bits  = 0;
            t_fall8 = tick_total;
            after8  = 1;
        end else begin
            m_out = {m_out[6:0], 1'b0};
        end
    end

    // ---------------- stimulus ----------------
    logic [4:0] prev_ch = '0;
    bit have_prev = 0;

    task automatic do_req(input logic [4:0] ch, input int hold);
        int r0, f0;
        bit busy_bad;
        logic [7:0] d0;
        logic [7:0] exp_d;
        r0 = rises;
        f0 = cs_falls;
        @(negedge clk);
        req_valid = 1'b1;
        req_chan  = ch;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy_bad  = 0;
        while (!rsp_valid) begin
            if (req_ready) busy_bad = 1;
            @(negedge clk);
        end
        chk(!busy_bad, "R2 not ready while busy", int'(busy_bad), 0);
        if (hold > 0) begin
            d0 = rsp_data;
            repeat (hold) @(negedge clk);
            chk(rsp_valid && rsp_data == d0, "R10 response held", int'(rsp_data), int'(d0));
        end
        if (ch >= 5'd24) begin
            chk(rsp_err == 1'b1, "R3 refused err", int'(rsp_err), 1);
            chk(rsp_data == 8'h00 && rsp_stale == 1'b0, "R3 refused data", int'(rsp_data), 0);
            chk(rises == r0 && cs_falls == f0, "R3 pins quiet", rises - r0, 0);
        end else begin
            exp_d = have_prev ? conv_of(prev_ch) : 8'hA5;
            chk(rsp_err == 1'b0, "R4 good err", int'(rsp_err), 0);
            chk(rises - r0 == 8, "R4 eight pulses", rises - r0, 8);
            chk(m_addr == ch && m_pad == 3'b000, "R4 address bits",
                int'({m_addr, m_pad}), int'({ch, 3'b000}));
            chk(rsp_data == exp_d, "R5 previous result", int'(rsp_data), int'(exp_d));
            chk(rsp_stale == !have_prev, "R9 stale flag", int'(rsp_stale), int'(!have_prev));
            if (GATED == 0)
                chk(cs_n == 1'b1, "R6 cs high after exchange", int'(cs_n), 1);
            else
                chk(cs_n == 1'b0 && sclk == 1'b0, "R7 cs low sclk parked", int'({cs_n, sclk}), 0);
            prev_ch   = ch;
            have_prev = 1;
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R2 back to idle", int'({rsp_valid, req_ready}), 1);
    endtask

    initial begin
        done = 1'b0;
        @(posedge rst_n);
        @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0 && !req_ready && !rsp_valid, "R1 reset state",
            int'({cs_n, sclk, req_ready, rsp_valid}), 8);
        repeat (20) @(negedge clk);
        chk(!req_ready && cs_n == 1'b1, "R1 holdoff", int'(req_ready), 0);
        for (int i = 0; i < 32; i++)
            do_req(5'((i * 13 + 7) % 32), (i % 4 == 1) ? 4 : 0);
        for (int i = 0; i < 6; i++)
            do_req(5'((i * 7 + 20) % 32), 0);
        done = 1'b1;
    end
endmodule

module sadc_host_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_tick;
    int   tick_total = 0;
    int   ph = 0;
    logic done_c, done_g;
    bit   timed_out = 0;

    always #2 clk = ~clk;

    always @(posedge clk) ph <= (ph == 2) ? 0 : ph + 1;
    assign conv_tick = (ph == 2);
    always @(posedge clk) if (conv_tick) tick_total <= tick_total + 1;

    sadc_host_ctrl_env #(.GATED(0)) env_cont (
        .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick), .tick_total(tick_total), .done(done_c));
    sadc_host_ctrl_env #(.GATED(1)) env_gate (
        .clk(clk), .rst_n(rst_n), .conv_tick(conv_tick), .tick_total(tick_total), .done(done_g));

    initial begin
        int runs, fails;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        fork
            wait (done_c === 1'b1 && done_g === 1'b1);
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        runs  = env_cont.n_run + env_gate.n_run + 1;
        fails = env_cont.n_fail + env_gate.n_fail;
        if (timed_out) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        end
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule